// File: doc/BRIEF.md
# Acquisition Trigger Sequencer

This block decides which scans of an ADC scan engine are kept, relative to a digital trigger. It runs on the timebase clock. Software programs the capture window and starts a run with a one-cycle `arm` pulse. The scan engine raises `scan_done` once for each finished scan, and the sequencer answers in the same cycle with `store_en` for each scan that belongs to the capture. `busy` is high from `arm` until the run finishes, and `done` pulses for one cycle at the end.

There are four capture shapes:

- **Before the trigger.** Every scan is stored while the sequencer waits. A downstream ring buffer keeps the newest `pre_kept` of them, and the block reports that count.
- **Around the trigger.** The same pre-trigger phase runs, followed by a fixed number of scans after the trigger.
- **After the trigger.** Only scans that follow the trigger are stored.
- **Delayed.** A programmable wait is inserted after the trigger. The wait is counted either in timebase cycles or in sample-clock periods, where one period is `si_cnt` timebase cycles.

The after and delayed shapes can repeat as a series of batches. Between batches the sequencer waits for a fresh trigger edge.

The trigger input is asynchronous. It passes through a synchronizer chain and is accepted only on the selected edge. A trigger that arrives while scans are being stored or a delay is running has no effect.

Top module: `acq_trig_seq`

## Requirements
- R1: After reset, `busy`, `done` and `store_en` are 0 and `pre_kept` is 0.
- R2: With `trig_falling`=0 only a 0-to-1 change of `trig_async` is a trigger; with `trig_falling`=1 only a 1-to-0 change is. The opposite edge has no effect.
- R3: With `mode`=0 (post), after an accepted trigger exactly `post_cnt` scans get `store_en`. Scans before the trigger are not stored. With `post_cnt`=0 the run ends at the trigger.
- R4: With `mode`=1 (pre), every scan from `arm` up to the accepted trigger gets `store_en`. The run ends at the trigger, and `pre_kept` becomes min(scans seen, `pre_cnt`).
- R5: With `pre_mask_en`=1 in pre or middle mode, a trigger that arrives before `pre_cnt` scans have been seen is ignored, and the run stays busy.
- R6: With `pre_mask_en`=0, an early trigger is accepted and `pre_kept` equals the number of scans seen so far.
- R7: With `mode`=2 (middle), the pre-trigger phase of R4 is followed by exactly `post_cnt` stored scans.
- R8: With `mode`=3 (delayed) and `dly_use_sample`=0, storing begins `dly_cnt` timebase cycles after the trigger is accepted. No scan is stored during the delay.
- R9: With `dly_use_sample`=1 the delay lasts `dly_cnt`×`si_cnt` timebase cycles.
- R10: In post and delayed modes the run has `batch_cnt` batches (0 counts as 1).
  - Between batches, `busy` stays 1, `done` stays 0 and no scan is stored until a new trigger arrives.
  - A trigger during a batch is ignored.
- R11: `done` is high for exactly one cycle, in the cycle in which `busy` first reads 0. An `arm` pulse while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle start pulse, taken only when idle |
| trig_async | input | 1 | Asynchronous digital trigger |
| trig_falling | input | 1 | Edge select: 0 rising, 1 falling |
| mode | input | 2 | 0 post, 1 pre, 2 middle, 3 delayed |
| pre_mask_en | input | 1 | Ignore triggers before `pre_cnt` scans are seen |
| pre_cnt | input | CNT_W | Scans kept before the trigger |
| post_cnt | input | CNT_W | Scans stored after the trigger |
| dly_cnt | input | CNT_W | Delay length in delay-clock ticks |
| dly_use_sample | input | 1 | Delay clock: 0 timebase, 1 sample clock |
| si_cnt | input | CNT_W | Timebase cycles per sample-clock tick |
| batch_cnt | input | BATCH_W | Number of batches in post/delayed mode |
| scan_done | input | 1 | One-cycle pulse per finished scan |
| store_en | output | 1 | Keep the scan flagged by `scan_done` this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pre_kept | output | CNT_W | Valid pre-trigger scan count of the last run |

## Verification
The bench builds the block with its defaults: 16-bit counters, 8-bit batch count and two synchronizer stages. It programs small window sizes, so that every window boundary, including the zero post count, is reached within a few dozen cycles. The short counts make it possible to pin delay expiry to an exact cycle for both delay clocks, with the sample clock checked at a divide of four. A run of two batches exercises re-arming and shows that a trigger arriving mid-batch is ignored.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

  typedef enum logic [1:0] {
    MODE_POST = 2'd0,
    MODE_PRE  = 2'd1,
    MODE_MID  = 2'd2,
    MODE_DLY  = 2'd3
  } acq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_PRE   = 3'd2,
    ST_DELAY = 3'd3,
    ST_POST  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  input  logic falling,
  output logic trig_hit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   lvl;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= trig_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= lvl;
  end

  always_comb begin
    if (falling) trig_hit = last_q & ~lvl;
    else         trig_hit = lvl & ~last_q;
  end

endmodule

// File: rtl/trig_delay_timer.sv
module trig_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             use_sample,
  input  logic [CNT_W-1:0] dly_val,
  input  logic [CNT_W-1:0] si_cnt,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] div_max;
  logic             tick;
  logic             remain_en, div_en;

  assign div_max = (si_cnt == '0) ? '0 : si_cnt - ONE;
  assign tick    = use_sample ? (div_q == div_max) : 1'b1;
  assign expire  = run & tick & (remain_q == ONE);

  always_comb begin
    remain_d  = remain_q;
    div_d     = div_q;
    remain_en = 1'b0;
    div_en    = 1'b0;
    if (start) begin
      remain_d  = dly_val;
      div_d     = '0;
      remain_en = 1'b1;
      div_en    = 1'b1;
    end else if (run) begin
      div_en = 1'b1;
      div_d  = (div_q == div_max) ? '0 : div_q + ONE;
      if (tick && remain_q != '0) begin
        remain_en = 1'b1;
        remain_d  = remain_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      div_q    <= '0;
    end else begin
      if (remain_en) remain_q <= remain_d;
      if (div_en)    div_q    <= div_d;
    end
  end

endmodule

// File: rtl/acq_trig_seq.sv
module acq_trig_seq
  import acq_trig_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BATCH_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               trig_async,
  input  logic               trig_falling,
  input  logic [1:0]         mode,
  input  logic               pre_mask_en,
  input  logic [CNT_W-1:0]   pre_cnt,
  input  logic [CNT_W-1:0]   post_cnt,
  input  logic [CNT_W-1:0]   dly_cnt,
  input  logic               dly_use_sample,
  input  logic [CNT_W-1:0]   si_cnt,
  input  logic [BATCH_W-1:0] batch_cnt,
  input  logic               scan_done,
  output logic               store_en,
  output logic               busy,
  output logic               done,
  output logic [CNT_W-1:0]   pre_kept
);

  localparam logic [CNT_W-1:0]   CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [BATCH_W-1:0] BATCH_ONE = {{(BATCH_W-1){1'b0}}, 1'b1};

  seq_state_e         st_q, st_d;
  acq_mode_e          mode_q, mode_d;
  logic [CNT_W-1:0]   pre_seen_q, pre_seen_d;
  logic [CNT_W-1:0]   kept_q, kept_d;
  logic [CNT_W-1:0]   post_q, post_d;
  logic [BATCH_W-1:0] batch_q, batch_d;
  logic [CNT_W-1:0]   pre_now;
  logic [BATCH_W-1:0] batch_first;
  logic               done_q;
  logic               trig_hit, dly_start, dly_expire, dly_run;
  logic               go_post, batch_end, finish, early;
  logic               arm_pre_phase, arm_batched;

  trig_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_async (trig_async),
    .falling    (trig_falling),
    .trig_hit   (trig_hit)
  );

  assign dly_run = (st_q == ST_DELAY);

  trig_delay_timer #(.CNT_W(CNT_W)) u_dly (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (dly_start),
    .run        (dly_run),
    .use_sample (dly_use_sample),
    .dly_val    (dly_cnt),
    .si_cnt     (si_cnt),
    .expire     (dly_expire)
  );

  assign batch_first   = (batch_cnt == '0) ? BATCH_ONE : batch_cnt;
  assign arm_pre_phase = (mode == MODE_PRE) || (mode == MODE_MID);
  assign arm_batched   = (mode == MODE_POST) || (mode == MODE_DLY);
  assign early         = pre_mask_en && (pre_now < pre_cnt);

  always_comb begin
    pre_now = pre_seen_q;
    if (scan_done && (pre_seen_q < pre_cnt)) pre_now = pre_seen_q + CNT_ONE;
  end

  always_comb begin
    st_d       = st_q;
    mode_d     = mode_q;
    pre_seen_d = pre_seen_q;
    kept_d     = kept_q;
    post_d     = post_q;
    batch_d    = batch_q;
    go_post    = 1'b0;
    batch_end  = 1'b0;
    finish     = 1'b0;
    dly_start  = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (arm) begin
          mode_d     = acq_mode_e'(mode);
          pre_seen_d = '0;
          kept_d     = '0;
          batch_d    = arm_batched ? batch_first : BATCH_ONE;
          st_d       = arm_pre_phase ? ST_PRE : ST_WAIT;
        end
      end
      ST_PRE: begin
        pre_seen_d = pre_now;
        if (trig_hit && !early) begin
          kept_d = pre_now;
          if (mode_q == MODE_PRE) finish = 1'b1;
          else                    go_post = 1'b1;
        end
      end
      ST_WAIT: begin
        if (trig_hit) begin
          if (mode_q == MODE_DLY && dly_cnt != '0) begin
            dly_start = 1'b1;
            st_d      = ST_DELAY;
          end else begin
            go_post = 1'b1;
          end
        end
      end
      ST_DELAY: begin
        if (dly_expire) go_post = 1'b1;
      end
      ST_POST: begin
        if (scan_done) begin
          if (post_q <= CNT_ONE) batch_end = 1'b1;
          else                   post_d    = post_q - CNT_ONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (go_post) begin
      if (post_cnt == '0) begin
        batch_end = 1'b1;
      end else begin
        post_d = post_cnt;
        st_d   = ST_POST;
      end
    end

    if (batch_end) begin
      if (batch_q <= BATCH_ONE) begin
        finish = 1'b1;
      end else begin
        batch_d = batch_q - BATCH_ONE;
        st_d    = ST_WAIT;
      end
    end

    if (finish) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      mode_q     <= MODE_POST;
      pre_seen_q <= '0;
      kept_q     <= '0;
      post_q     <= '0;
      batch_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      mode_q     <= mode_d;
      pre_seen_q <= pre_seen_d;
      kept_q     <= kept_d;
      post_q     <= post_d;
      batch_q    <= batch_d;
      done_q     <= finish;
    end
  end

  assign store_en = scan_done & ((st_q == ST_PRE) || (st_q == ST_POST));
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign pre_kept = kept_q;

endmodule

// File: rtl/acq_trig_seq_chk.sv
module acq_trig_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             scan_done,
  input logic [CNT_W-1:0] pre_cnt,
  input logic             store_en,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] pre_kept
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R11

  AST_ARM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !busy) |=> busy); // R11

  AST_STORE_NEEDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> scan_done); // R3

  AST_NO_STORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !store_en); // R3

  AST_KEPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pre_kept <= pre_cnt)); // R4

endmodule

bind acq_trig_seq acq_trig_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .scan_done (scan_done),
  .pre_cnt   (pre_cnt),
  .store_en  (store_en),
  .busy      (busy),
  .done      (done),
  .pre_kept  (pre_kept)
);

// File: tb/test_acq_trig_seq.sv
module test_acq_trig_seq;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk;
  logic        rst_n;
  logic        arm;
  logic        trig_async;
  logic        trig_falling;
  logic [1:0]  mode;
  logic        pre_mask_en;
  logic [15:0] pre_cnt, post_cnt, dly_cnt, si_cnt;
  logic        dly_use_sample;
  logic [7:0]  batch_cnt;
  logic        scan_done;
  logic        store_en, busy, done;
  logic [15:0] pre_kept;

  int n_chk;
  int n_fail;
  int st_cnt;
  int dn_cnt;
  bit finished;

  acq_trig_seq i_acq_trig_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_async(trig_async),
    .trig_falling(trig_falling), .mode(mode), .pre_mask_en(pre_mask_en),
    .pre_cnt(pre_cnt), .post_cnt(post_cnt), .dly_cnt(dly_cnt),
    .dly_use_sample(dly_use_sample), .si_cnt(si_cnt), .batch_cnt(batch_cnt),
    .scan_done(scan_done), .store_en(store_en), .busy(busy), .done(done),
    .pre_kept(pre_kept)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      st_cnt = st_cnt + int'(store_en);
      dn_cnt = dn_cnt + int'(done);
    end
  end

  typedef struct packed {
    logic [1:0]  md;
    logic        pmask;
    logic [15:0] pre;
    logic [15:0] post;
    logic [15:0] dly;
    logic [7:0]  nbefore;
    logic [7:0]  exp_store;
    logic [15:0] exp_kept;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b0, 16'd0, 16'd4, 16'd0, 8'd3, 8'd4, 16'd0},  // R3 post
    '{2'd1, 1'b1, 16'd3, 16'd0, 16'd0, 8'd5, 8'd5, 16'd3},  // R4 pre, saturating
    '{2'd1, 1'b0, 16'd6, 16'd0, 16'd0, 8'd2, 8'd2, 16'd2},  // R6 early accepted
    '{2'd2, 1'b1, 16'd2, 16'd3, 16'd0, 8'd4, 8'd7, 16'd2},  // R7 middle
    '{2'd3, 1'b0, 16'd0, 16'd2, 16'd5, 8'd1, 8'd2, 16'd0},  // R8 delayed
    '{2'd0, 1'b0, 16'd0, 16'd0, 16'd0, 8'd2, 8'd0, 16'd0}   // R3 zero post
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_scan();
    scan_done = 1'b1;
    tick(1);
    scan_done = 1'b0;
    tick(1);
  endtask

  task automatic do_trig();
    trig_async = ~trig_falling;
    tick(6);
    trig_async = trig_falling;
    tick(6);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    tick(1);
    arm = 1'b0;
    tick(2);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic pm, input int pre,
                         input int post, input int dly, input logic us,
                         input int si, input int nb);
    mode = m; pre_mask_en = pm; pre_cnt = 16'(pre); post_cnt = 16'(post);
    dly_cnt = 16'(dly); dly_use_sample = us; si_cnt = 16'(si);
    batch_cnt = 8'(nb);
  endtask

  initial begin
    int s0, d0;
    rst_n = 1'b0; arm = 1'b0; trig_async = 1'b0; trig_falling = 1'b0;
    scan_done = 1'b0; n_chk = 0; n_fail = 0; st_cnt = 0; dn_cnt = 0;
    finished = 1'b0;
    set_cfg(2'd0, 1'b0, 0, 1, 0, 1'b0, 1, 1);
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 pre_kept", int'(pre_kept), 0);
    scan_done = 1'b1; #1;
    chk("R1 store_en idle", int'(store_en), 0);
    tick(1); scan_done = 1'b0; tick(1);

    // Table-driven windows
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v].md, VEC[v].pmask, int'(VEC[v].pre), int'(VEC[v].post),
              int'(VEC[v].dly), 1'b0, 1, 1);
      s0 = st_cnt; d0 = dn_cnt;
      do_arm();
      for (int k = 0; k < int'(VEC[v].nbefore); k++) do_scan();
      do_trig();
      tick(20);
      for (int k = 0; k < 20; k++) if (dn_cnt == d0) do_scan();
      tick(3);
      chk($sformatf("R3/R4/R6/R7/R8 vec%0d stores", v), st_cnt - s0, int'(VEC[v].exp_store));
      chk($sformatf("R11 vec%0d done count", v), dn_cnt - d0, 1);
      chk($sformatf("R4 vec%0d pre_kept", v), int'(pre_kept), int'(VEC[v].exp_kept));
      chk($sformatf("R11 vec%0d idle", v), int'(busy), 0);
    end

    // R5 early trigger masked
    set_cfg(2'd1, 1'b1, 4, 0, 0, 1'b0, 1, 1);
    s0 = st_cnt; d0 = dn_cnt;
    do_arm();
    do_scan(); do_scan();
    do_trig();
    chk("R5 still busy after early trigger", int'(busy), 1);
    chk("R5 no done after early trigger", dn_cnt - d0, 0);
    do_scan(); do_scan();
    do_trig();
    chk("R5 done after full pre count", dn_cnt - d0, 1);
    chk("R5 pre_kept", int'(pre_kept), 4);
    chk("R5 stores", st_cnt - s0, 4);

    // R8 delay on timebase: 10 cycles, trigger accepted 2 edges after sync
    set_cfg(2'd3, 1'b0, 0, 1, 10, 1'b0, 1, 1);
    d0 = dn_cnt;
    do_arm();
    trig_async = 1'b1;
    tick(12);
    scan_done = 1'b1; #1;
    chk("R8 no store during delay", int'(store_en), 0);
    tick(1); #1;
    chk("R8 store at delay end", int'(store_en), 1);
    tick(1); scan_done = 1'b0; trig_async = 1'b0;
    tick(3);
    chk("R8 done", dn_cnt - d0, 1);

    // R9 delay on sample clock: 3 ticks of 4 cycles
    set_cfg(2'd3, 1'b0, 0, 1, 3, 1'b1, 4, 1);
    d0 = dn_cnt;
    do_arm();
    trig_async = 1'b1;
    tick(14);
    scan_done = 1'b1; #1;
    chk("R9 no store during sample delay", int'(store_en), 0);
    tick(1); #1;
    chk("R9 store at sample delay end", int'(store_en), 1);
    tick(1); scan_done = 1'b0; trig_async = 1'b0;
    tick(3);
    chk("R9 done", dn_cnt - d0, 1);

    // R10 two batches, mid-batch trigger ignored
    set_cfg(2'd0, 1'b0, 0, 3, 0, 1'b0, 1, 2);
    s0 = st_cnt; d0 = dn_cnt;
    do_arm();
    do_trig();
    do_scan();
    do_trig();
    do_scan(); do_scan();
    chk("R10 busy between batches", int'(busy), 1);
    chk("R10 no done between batches", dn_cnt - d0, 0);
    do_scan(); do_scan();
    chk("R10 no store while re-armed", st_cnt - s0, 3);
    do_trig();
    do_scan(); do_scan(); do_scan();
    tick(3);
    chk("R10 total stores", st_cnt - s0, 6);
    chk("R10 done once", dn_cnt - d0, 1);

    // R2 falling edge select
    trig_falling = 1'b1;
    trig_async = 1'b0;
    tick(6);
    set_cfg(2'd0, 1'b0, 0, 1, 0, 1'b0, 1, 1);
    s0 = st_cnt; d0 = dn_cnt;
    do_arm();
    trig_async = 1'b1;
    tick(6);
    do_scan();
    chk("R2 rising edge ignored when falling selected", st_cnt - s0, 0);
    trig_async = 1'b0;
    tick(6);
    do_scan();
    tick(3);
    chk("R2 falling edge accepted", st_cnt - s0, 1);
    chk("R2 done", dn_cnt - d0, 1);
    trig_falling = 1'b0;
    tick(6);

    // R11 arm while busy ignored
    set_cfg(2'd0, 1'b0, 0, 2, 0, 1'b0, 1, 1);
    s0 = st_cnt; d0 = dn_cnt;
    do_arm();
    do_trig();
    do_scan();
    do_arm();
    do_scan();
    tick(3);
    chk("R11 stores with arm while busy", st_cnt - s0, 2);
    chk("R11 single done", dn_cnt - d0, 1);
    chk("R11 idle at end", int'(busy), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule